// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block paces row refreshes for a DRAM array model and guards the array from the access path while it does so. A free-running interval counter divides the retention period by the number of rows. Each time the counter expires, one refresh becomes due. The scheduler then waits for any access already in flight to finish. It pulses a strobe together with the row to refresh and holds the array for a fixed number of cycles. It then moves on to the next row, returning to row 0 after the last one.

Requesters see a single valid/ready pair. A grant is the cycle where both are high. The array model reports an ongoing access on `acc_busy`, which must rise in the cycle after the grant and stay high no longer than `MAX_ACCESS` cycles. A refresh that is due takes priority over every new request: `req_ready` drops as soon as the refresh is due and stays low until the refresh finishes.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `req_ready` is 1, `ref_strobe` and `ref_active` are 0, and `ref_row` is 0.
- R2: With no traffic, consecutive `ref_strobe` pulses are exactly INTERVAL cycles apart.
- R3: Each refresh targets the row after the previous one. Row ROWS-1 is followed by row 0, and the first refresh after reset targets row 0.
- R4: `ref_active` is high for exactly REF_CYCLES consecutive cycles. The first of these cycles carries the one-cycle `ref_strobe`, and `req_ready` is 0 in all of them.
- R5: A refresh that falls due while an access is in flight does not start while `acc_busy` is high. It does not start in the cycle after a grant either. Its strobe appears in the first cycle after `acc_busy` is seen low.
- R6: Once a refresh is due, `req_ready` is 0 until that refresh ends. Every strobe is preceded by at least one cycle with `req_ready` at 0.
- R7: Every row is refreshed again within ROWS*INTERVAL + MAX_ACCESS + 2 cycles of its previous refresh. No refresh is still pending or running when the next one falls due.
- R8: INTERVAL is floor(CLK_FREQ_HZ * RETAIN_US / (ROWS * 1,000,000)). With no traffic, the first strobe appears INTERVAL+1 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester wants an array access |
| req_ready | output | 1 | Access may be granted this cycle |
| acc_busy | input | 1 | Array reports an access in flight |
| ref_strobe | output | 1 | One-cycle pulse at the start of a row refresh |
| ref_active | output | 1 | Array is occupied by a refresh |
| ref_row | output | ROW_W | Row being refreshed |

## Verification
The bench builds the block with 8 rows, a 1 MHz nominal clock and a 320 us retention. This gives a 40-cycle interval, so a full pass over all rows, and several wraps, fit in a few hundred cycles. A 3-cycle refresh and accesses of up to 8 cycles let back-to-back traffic straddle many interval expiries. This exercises the deferral path and the worst-case row age. With 8 rows the row counter runs on its power-of-two wrap variant.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_REFR = 2'd2
   } refsched_state_e;

   // Clock cycles between row refreshes, rounded down so no row is late.
   function automatic longint calc_interval(longint clk_hz, longint retain_us, longint rows);
      return (clk_hz * retain_us) / (rows * 64'd1000000);
   endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
   parameter int INTERVAL = 976
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = $clog2(INTERVAL + 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

   logic [CNT_W-1:0] cnt;

   assign tick = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= RELOAD;
      end else if (tick) begin
         cnt <= RELOAD;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   // R2: the counter never leaves its range
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n) cnt <= RELOAD);

endmodule

// File: rtl/refsched_rowctr.sv
module refsched_rowctr #(
   parameter int ROWS  = 8192,
   parameter int ROW_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [ROW_W-1:0] row
);
   localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);
   localparam bit POW2 = ((ROWS & (ROWS - 1)) == 0);

   logic [ROW_W-1:0] row_nxt;

   generate
      if (POW2) begin : g_wrap_pow2
         assign row_nxt = row + 1'b1;
      end else begin : g_wrap_cmp
         assign row_nxt = (row == LAST) ? '0 : row + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row <= '0;
      end else if (adv) begin
         row <= row_nxt;
      end
   end

   // R3: the last row is followed by row 0
   p_row_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && row == LAST) |=> row == '0);
   // R3: outside a refresh end the row holds
   p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(row));

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
   import refsched_pkg::*;
#(
   parameter int REF_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic in_flight,
   output logic idle,
   output logic ref_active,
   output logic ref_strobe,
   output logic ref_done
);
   localparam int RC_W = $clog2(REF_CYCLES) + 1;
   localparam logic [RC_W-1:0] RC_TOP = RC_W'(REF_CYCLES - 1);

   refsched_state_e state;
   logic [RC_W-1:0] rcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         rcnt  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (tick) state <= ST_WAIT;
            ST_WAIT: if (!in_flight) begin
               state <= ST_REFR;
               rcnt  <= RC_TOP;
            end
            ST_REFR: if (rcnt == '0) state <= ST_IDLE;
                     else            rcnt  <= rcnt - 1'b1;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle       = (state == ST_IDLE);
   assign ref_active = (state == ST_REFR);
   assign ref_strobe = ref_active && (rcnt == RC_TOP);
   assign ref_done   = ref_active && (rcnt == '0);

   // R7: a refresh never overruns into the next due point
   p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n) tick |-> idle);
   // R5: a due refresh holds off while an access is in flight
   p_defer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && in_flight) |=> (state == ST_WAIT));
   // R4: a refresh always opens with the strobe
   p_open_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_active) |-> ref_strobe);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import refsched_pkg::*;
#(
   parameter int CLK_FREQ_HZ = 125_000_000,
   parameter int RETAIN_US   = 64_000,
   parameter int ROWS        = 8192,
   parameter int REF_CYCLES  = 4,
   parameter int MAX_ACCESS  = 16,
   parameter int ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             acc_busy,
   output logic             ref_strobe,
   output logic             ref_active,
   output logic [ROW_W-1:0] ref_row
);
   localparam longint INTERVAL_L = calc_interval(CLK_FREQ_HZ, RETAIN_US, ROWS);
   localparam int     INTERVAL   = int'(INTERVAL_L);

   generate
      if (ROWS < 2) begin : g_chk_rows
         $error("ROWS must be at least 2");
      end
      if (REF_CYCLES < 1) begin : g_chk_ref
         $error("REF_CYCLES must be at least 1");
      end
      if (INTERVAL_L < longint'(MAX_ACCESS + REF_CYCLES + 3)) begin : g_chk_int
         $error("refresh interval too short for worst-case access plus refresh");
      end
      if (ROW_W < $clog2(ROWS)) begin : g_chk_w
         $error("ROW_W too narrow for ROWS");
      end
   endgenerate

   logic tick, idle, ref_done, grant, grant_q, in_flight;

   refsched_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   refsched_ctrl #(.REF_CYCLES(REF_CYCLES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .in_flight(in_flight),
      .idle(idle), .ref_active(ref_active), .ref_strobe(ref_strobe),
      .ref_done(ref_done)
   );

   refsched_rowctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
      .clk(clk), .rst_n(rst_n), .adv(ref_done), .row(ref_row)
   );

   assign req_ready = idle;
   assign grant     = req_valid && req_ready;
   assign in_flight = acc_busy || grant_q;

   always_ff @(posedge clk) begin
      if (!rst_n) grant_q <= 1'b0;
      else        grant_q <= grant;
   end

   // R4: no grant while the array is refreshed
   p_no_grant_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_active |-> !req_ready);
   // R5: a refresh never starts on top of an access
   p_strobe_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ref_strobe |-> (!acc_busy && !$past(grant)));
   // R6: a strobe is preceded by a cycle without ready
   p_strobe_after_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_strobe |-> !$past(req_ready));

endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
   localparam int ROWS     = 8;
   localparam int REF_CYC  = 3;
   localparam int MAX_ACC  = 8;
   localparam int EXP_INT  = 40;   // 1e6 * 320 / (8 * 1e6)
   localparam int AGE_MAX  = ROWS * EXP_INT + MAX_ACC + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic acc_busy = 1'b0;
   logic req_ready, ref_strobe, ref_active;
   logic [2:0] ref_row;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dram_refresh_sched #(
      .CLK_FREQ_HZ(1_000_000), .RETAIN_US(320), .ROWS(ROWS),
      .REF_CYCLES(REF_CYC), .MAX_ACCESS(MAX_ACC), .ROW_W(3)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .acc_busy(acc_busy), .ref_strobe(ref_strobe), .ref_active(ref_active),
      .ref_row(ref_row)
   );

   int exp_q[$];
   int next_row = 0;
   bit idle_mode = 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_rows(input int n);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(next_row);
         next_row = (next_row + 1) % ROWS;
      end
   endtask

   task automatic do_access(input int len);
      @(negedge clk);
      req_valid = 1'b1;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      req_valid = 1'b0;
      acc_busy  = 1'b1;
      repeat (len - 1) @(negedge clk);
      acc_busy  = 1'b0;
   endtask

   // monitor / scoreboard
   int cyc = 0;
   int last_strobe = -1;
   int strobes = 0;
   int act_len = 0;
   int r5_events = 0;
   bit prev_ready = 1;
   bit prev_busy = 0;
   bit expect_next = 0;
   int last_row_cyc[ROWS];

   initial begin
      for (int i = 0; i < ROWS; i++) last_row_cyc[i] = -1;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         #1;
         cyc++;
         if (expect_next) begin
            check(ref_strobe, "R5 strobe right after access end", ref_strobe, 1);
            expect_next = 0;
            r5_events++;
         end
         if (acc_busy && ref_strobe)
            check(0, "R5 strobe during access", 1, 0);
         if (ref_active)
            check(!req_ready, "R4 ready low in refresh", req_ready, 0);
         if (ref_active) act_len++;
         else if (act_len != 0) begin
            check(act_len == REF_CYC, "R4 refresh length", act_len, REF_CYC);
            act_len = 0;
         end
         if (ref_strobe) begin
            int er;
            strobes++;
            check(ref_active, "R4 strobe inside active", ref_active, 1);
            check(!prev_ready, "R6 ready low before strobe", prev_ready, 0);
            if (exp_q.size() == 0) begin
               check(0, "R3 unexpected strobe", ref_row, -1);
            end else begin
               er = exp_q.pop_front();
               check(ref_row == er, "R3 row order", ref_row, er);
            end
            if (strobes == 1)
               check(cyc == EXP_INT + 1, "R8 first strobe cycle", cyc, EXP_INT + 1);
            else if (idle_mode)
               check(cyc - last_strobe == EXP_INT, "R2 idle spacing", cyc - last_strobe, EXP_INT);
            if (last_row_cyc[ref_row] >= 0)
               check(cyc - last_row_cyc[ref_row] <= AGE_MAX, "R7 row age",
                     cyc - last_row_cyc[ref_row], AGE_MAX);
            last_row_cyc[ref_row] = cyc;
            last_strobe = cyc;
         end
         if (prev_busy && !acc_busy && !req_ready && !ref_active)
            expect_next = 1;
         prev_ready = req_ready;
         prev_busy  = acc_busy;
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // stimulus
   initial begin
      push_rows(64);
      repeat (3) @(negedge clk);
      // R1 reset values
      check(req_ready == 1, "R1 ready after reset", req_ready, 1);
      check(ref_strobe == 0, "R1 strobe after reset", ref_strobe, 0);
      check(ref_active == 0, "R1 active after reset", ref_active, 0);
      check(ref_row == 0, "R1 row after reset", ref_row, 0);
      rst_n = 1'b1;
      // R2 / R8 idle phase: three refreshes
      repeat (3 * EXP_INT + 5) @(negedge clk);
      idle_mode = 0;
      // R5 / R7 traffic phase: back-to-back accesses over many wraps
      for (int i = 0; i < 160; i++) do_access(((i * 5) % MAX_ACC) + 1);
      repeat (2) do_access(MAX_ACC);
      repeat (EXP_INT + 10) @(negedge clk);
      // R3 the row counter must have wrapped at least twice
      check(strobes > 2 * ROWS, "R3 wraps covered", strobes, 2 * ROWS + 1);
      check(r5_events > 0, "R5 deferral covered", r5_events, 1);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule